// File: doc/BRIEF.md
# CPU-to-ISA I/O Address Translator

This block connects a CPU-side memory window to an ISA-style I/O port bus. The CPU presents a single-cycle request carrying an address, a transfer size, a direction and write data. When the address lies inside the 8 MB window based at 0x80000000, the block folds it down to a 16-bit port address and issues one port cycle. A read completes once the port side reports valid data.

Two foldings are available, chosen per access by the `map_sparse` input. The contiguous folding keeps the low 64 KB of the address. The sparse folding keeps the five lowest address bits and moves address bits 22..12 down to port bits 15..5, so each 4 KB CPU page holds 32 port addresses. With the big-endian build option set, halfword and word data have their byte order reversed in both directions. Byte data is never reordered.

Top module: `cpu_isa_io_bridge`

## Requirements
- R1: A request whose address lies in 0x80000000..0x807FFFFF is forwarded to the port bus. A request outside that range produces no port strobe and no `cpu_done`.
- R2: With `map_sparse` = 0, `io_addr` equals bits 15..0 of the CPU address.
- R3: With `map_sparse` = 1, `io_addr` equals `(addr & 0x1F) | ((addr & 0x07FFF000) >> 7)`, taken to 16 bits.
- R4: `map_sparse` is sampled only in the cycle a request is accepted. `io_addr`, `io_size` and `io_wdata` hold their values until `cpu_done`, whatever `map_sparse` does in the meantime.
- R5: The size code is 00 for byte, 01 for halfword and 10 for word, and it is copied unchanged to `io_size`. Code 11 is not forwarded: it produces no strobe and no `cpu_done`.
- R6: An accepted request raises exactly one of `io_wr` (write) or `io_rd` (read) for exactly one cycle, in the cycle after acceptance.
- R7: Write data is passed through unchanged for a byte. For a halfword, bits 7..0 and 15..8 are exchanged and bits 31..16 pass through. For a word, all four bytes are reversed (bits 7..0 go to 31..24, and so on).
- R8: Read data from `io_rdata` is reordered by the same rules as R7, using the size of the access. It appears on `cpu_rdata` with a one-cycle `cpu_done`, in the cycle after the first `io_rvalid` seen after the read strobe.
- R9: A write raises `cpu_done` for one cycle, in the cycle after its `io_wr` strobe.
- R10: A request that arrives while an access is in progress, up to and including its `cpu_done` cycle, is ignored.
- R11: After reset, `io_wr`, `io_rd` and `cpu_done` are low and the block accepts a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle request pulse from the CPU side |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU physical address |
| cpu_size | input | 2 | Transfer size code |
| cpu_wdata | input | 32 | Write data in CPU byte order |
| map_sparse | input | 1 | 0 = contiguous folding, 1 = sparse folding |
| cpu_rdata | output | 32 | Read data in CPU byte order |
| cpu_done | output | 1 | One-cycle completion flag |
| io_addr | output | 16 | Port address |
| io_size | output | 2 | Port transfer size |
| io_wdata | output | 32 | Write data in port byte order |
| io_wr | output | 1 | One-cycle port write strobe |
| io_rd | output | 1 | One-cycle port read strobe |
| io_rdata | input | 32 | Read data from the port bus |
| io_rvalid | input | 1 | Port read data valid |

## Verification
The assertions assume that the port side raises `io_rvalid` only while a read is waiting, and never in the same cycle as the `io_rd` strobe. They also assume the CPU holds off a new request until it has seen `cpu_done`. The bench models the port device in its tasks and drives `io_rvalid` exactly one cycle after the read strobe. It sends further requests only after completion, apart from the one scenario that deliberately pulses `cpu_req` mid-access to exercise R10. That scenario checks at the ports that no second strobe and no address change follow.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10,
        ST_RESP  = 2'b11
    } bridge_state_e;

endpackage

// File: rtl/isa_addr_fold.sv
module isa_addr_fold #(
    parameter int WIN_BITS     = 23,
    parameter int PORT_AW      = 16,
    parameter int LOW_KEEP     = 5,
    parameter int SPARSE_SHIFT = 7
) (
    input  logic [WIN_BITS-1:0] win_addr,
    input  logic                sparse,
    output logic [PORT_AW-1:0]  port_addr
);
    localparam int HI_LSB = LOW_KEEP + SPARSE_SHIFT;
    localparam int HI_W   = WIN_BITS - HI_LSB;

    logic [PORT_AW-1:0] flat_addr;
    logic [PORT_AW-1:0] sparse_addr;

    assign flat_addr = win_addr[PORT_AW-1:0];

    generate
        if (HI_W + LOW_KEEP >= PORT_AW) begin : g_full
            assign sparse_addr = {win_addr[HI_LSB +: (PORT_AW-LOW_KEEP)],
                                  win_addr[LOW_KEEP-1:0]};
        end else begin : g_pad
            assign sparse_addr = {{(PORT_AW-LOW_KEEP-HI_W){1'b0}},
                                  win_addr[WIN_BITS-1:HI_LSB],
                                  win_addr[LOW_KEEP-1:0]};
        end
    endgenerate

    assign port_addr = sparse ? sparse_addr : flat_addr;
endmodule

// File: rtl/isa_lane_swap.sv
module isa_lane_swap
    import isa_bridge_pkg::*;
#(
    parameter int DW         = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [DW-1:0] din,
    input  logic [1:0]    size,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    logic [DW-1:0] rev_word;
    logic [DW-1:0] rev_half;

    genvar i;
    generate
        for (i = 0; i < NB; i++) begin : g_rev
            assign rev_word[8*i +: 8] = din[8*(NB-1-i) +: 8];
        end
    endgenerate

    assign rev_half = {din[DW-1:16], din[7:0], din[15:8]};

    generate
        if (BIG_ENDIAN) begin : g_swap
            always_comb begin
                case (xfer_size_e'(size))
                    SZ_HALF: dout = rev_half;
                    SZ_WORD: dout = rev_word;
                    default: dout = din;
                endcase
            end
        end else begin : g_pass
            logic unused_sz;
            assign unused_sz = ^{size, rev_word, rev_half};
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/cpu_isa_io_bridge.sv
module cpu_isa_io_bridge
    import isa_bridge_pkg::*;
#(
    parameter int          CPU_AW       = 32,
    parameter int          DW           = 32,
    parameter int          PORT_AW      = 16,
    parameter int          WIN_BITS     = 23,
    parameter logic [31:0] WIN_BASE     = 32'h8000_0000,
    parameter int          LOW_KEEP     = 5,
    parameter int          SPARSE_SHIFT = 7,
    parameter bit          BIG_ENDIAN   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [1:0]         cpu_size,
    input  logic [DW-1:0]      cpu_wdata,
    input  logic               map_sparse,
    output logic [DW-1:0]      cpu_rdata,
    output logic               cpu_done,
    output logic [PORT_AW-1:0] io_addr,
    output logic [1:0]         io_size,
    output logic [DW-1:0]      io_wdata,
    output logic               io_wr,
    output logic               io_rd,
    input  logic [DW-1:0]      io_rdata,
    input  logic               io_rvalid
);
    localparam int TAG_W = CPU_AW - WIN_BITS;

    typedef struct packed {
        bridge_state_e      st;
        logic [PORT_AW-1:0] addr;
        logic [1:0]         size;
        logic [DW-1:0]      wdata;
        logic [DW-1:0]      rdata;
        logic               we;
        logic               wr;
        logic               rd;
        logic               done;
    } regs_t;

    regs_t r_d, r_q;

    logic               win_hit;
    logic               size_ok;
    logic [PORT_AW-1:0] fold_addr;
    logic [DW-1:0]      wdata_sw;
    logic [DW-1:0]      rdata_sw;

    assign win_hit = (cpu_addr[CPU_AW-1:WIN_BITS] == WIN_BASE[CPU_AW-1:WIN_BITS]);
    assign size_ok = (xfer_size_e'(cpu_size) != SZ_RSVD);

    isa_addr_fold #(
        .WIN_BITS    (WIN_BITS),
        .PORT_AW     (PORT_AW),
        .LOW_KEEP    (LOW_KEEP),
        .SPARSE_SHIFT(SPARSE_SHIFT)
    ) u_fold (
        .win_addr (cpu_addr[WIN_BITS-1:0]),
        .sparse   (map_sparse),
        .port_addr(fold_addr)
    );

    isa_lane_swap #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_wr_swap (
        .din (cpu_wdata),
        .size(cpu_size),
        .dout(wdata_sw)
    );

    isa_lane_swap #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_rd_swap (
        .din (io_rdata),
        .size(r_q.size),
        .dout(rdata_sw)
    );

    always_comb begin
        r_d      = r_q;
        r_d.wr   = 1'b0;
        r_d.rd   = 1'b0;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cpu_req && win_hit && size_ok) begin
                    r_d.st    = ST_ISSUE;
                    r_d.addr  = fold_addr;
                    r_d.size  = cpu_size;
                    r_d.wdata = wdata_sw;
                    r_d.we    = cpu_we;
                    r_d.wr    = cpu_we;
                    r_d.rd    = !cpu_we;
                end
            end
            ST_ISSUE: begin
                if (r_q.we) begin
                    r_d.st   = ST_RESP;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (io_rvalid) begin
                    r_d.st    = ST_RESP;
                    r_d.rdata = rdata_sw;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, size: 2'b00, we: 1'b0, wr: 1'b0, rd: 1'b0,
                     done: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign io_addr   = r_q.addr;
    assign io_size   = r_q.size;
    assign io_wdata  = r_q.wdata;
    assign io_wr     = r_q.wr;
    assign io_rd     = r_q.rd;
    assign cpu_done  = r_q.done;
    assign cpu_rdata = r_q.rdata;

    logic unused_tag;
    assign unused_tag = ^{TAG_W{1'b0}};
endmodule

// File: rtl/cpu_isa_io_bridge_chk.sv
module cpu_isa_io_bridge_chk #(
    parameter int          CPU_AW   = 32,
    parameter int          PORT_AW  = 16,
    parameter int          WIN_BITS = 23,
    parameter logic [31:0] WIN_BASE = 32'h8000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic [1:0]         cpu_size,
    input logic               cpu_done,
    input logic [PORT_AW-1:0] io_addr,
    input logic [1:0]         io_size,
    input logic               io_wr,
    input logic               io_rd
);
    a_r6_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) |=> !(io_wr || io_rd));

    a_r6_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd));

    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) |=> ($stable(io_addr) && $stable(io_size)));

    a_r9_write_done: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> cpu_done);

    a_r8_no_early_read_done: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !cpu_done);

    a_r1_miss_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && (cpu_addr[CPU_AW-1:WIN_BITS] != WIN_BASE[CPU_AW-1:WIN_BITS]))
        |=> !(io_wr || io_rd));

    a_r5_rsvd_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && (cpu_size == 2'b11)) |=> !(io_wr || io_rd));

    a_r5_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) |-> (io_size != 2'b11));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
endmodule

bind cpu_isa_io_bridge cpu_isa_io_bridge_chk #(
    .CPU_AW  (CPU_AW),
    .PORT_AW (PORT_AW),
    .WIN_BITS(WIN_BITS),
    .WIN_BASE(WIN_BASE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_req),
    .cpu_addr(cpu_addr),
    .cpu_size(cpu_size),
    .cpu_done(cpu_done),
    .io_addr (io_addr),
    .io_size (io_size),
    .io_wr   (io_wr),
    .io_rd   (io_rd)
);

// File: tb/cpu_isa_io_bridge_bench.sv
module cpu_isa_io_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        map_sparse = 1'b0;
    logic [31:0] cpu_rdata;
    logic        cpu_done;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic        io_wr;
    logic        io_rd;
    logic [31:0] io_rdata = '0;
    logic        io_rvalid = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cpu_isa_io_bridge u_cpu_isa_io_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .map_sparse(map_sparse), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_rvalid(io_rvalid)
    );

    function automatic logic [15:0] exp_port(input logic [31:0] a, input logic sp);
        logic [31:0] t;
        if (sp) t = (a & 32'h1F) | ((a & 32'h07FF_F000) >> 7);
        else    t = a & 32'hFFFF;
        return t[15:0];
    endfunction

    function automatic logic [31:0] exp_swap(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'b01) return {d[31:16], d[7:0], d[15:8]};
        if (sz == 2'b10) return {d[7:0], d[15:8], d[23:16], d[31:24]};
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic sp);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz;
        cpu_wdata = wd; map_sparse = sp;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!io_wr && !io_rd && !cpu_done, "R11 reset outputs",
              {29'b0, io_wr, io_rd, cpu_done}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_write(input logic [31:0] a, input logic [1:0] sz,
                           input logic [31:0] wd, input logic sp);
        send(1'b1, a, sz, wd, sp);
        check(io_wr && !io_rd, "R6 write strobe", {30'b0, io_wr, io_rd}, 32'h2);
        check(io_addr == exp_port(a, sp), sp ? "R3 sparse fold" : "R2 flat fold",
              {16'b0, io_addr}, {16'b0, exp_port(a, sp)});
        check(io_size == sz, "R5 size passthrough", {30'b0, io_size}, {30'b0, sz});
        check(io_wdata == exp_swap(wd, sz), "R7 write swap", io_wdata, exp_swap(wd, sz));
        @(negedge clk);
        check(cpu_done && !io_wr, "R9 write done", {30'b0, cpu_done, io_wr}, 32'h2);
        @(negedge clk);
        check(!cpu_done, "R9 done one cycle", {31'b0, cpu_done}, 32'h0);
    endtask

    task automatic t_read(input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] rd, input logic sp, input bit flip_map);
        send(1'b0, a, sz, 32'h0, sp);
        check(io_rd && !io_wr, "R6 read strobe", {30'b0, io_wr, io_rd}, 32'h1);
        check(io_addr == exp_port(a, sp), sp ? "R3 sparse fold rd" : "R2 flat fold rd",
              {16'b0, io_addr}, {16'b0, exp_port(a, sp)});
        if (flip_map) map_sparse = !sp;
        @(negedge clk);
        check(!io_rd && !cpu_done, "R8 no done before rvalid",
              {30'b0, io_rd, cpu_done}, 32'h0);
        check(io_addr == exp_port(a, sp), "R4 addr held", {16'b0, io_addr},
              {16'b0, exp_port(a, sp)});
        io_rdata = rd; io_rvalid = 1'b1;
        @(negedge clk);
        io_rvalid = 1'b0; io_rdata = 32'hDEAD_BEEF;
        check(cpu_done, "R8 read done", {31'b0, cpu_done}, 32'h1);
        check(cpu_rdata == exp_swap(rd, sz), "R8 read swap", cpu_rdata, exp_swap(rd, sz));
        @(negedge clk);
        check(!cpu_done, "R8 done one cycle", {31'b0, cpu_done}, 32'h0);
    endtask

    task automatic t_not_forwarded(input logic [31:0] a, input logic [1:0] sz,
                                   input string req);
        bit seen = 1'b0;
        send(1'b1, a, sz, 32'h1234_5678, 1'b0);
        for (int k = 0; k < 5; k++) begin
            if (io_wr || io_rd || cpu_done) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, req, {31'b0, seen}, 32'h0);
    endtask

    task automatic t_busy_ignore;
        bit extra = 1'b0;
        send(1'b0, 32'h8000_0123, 2'b00, 32'h0, 1'b0);
        cpu_req = 1'b1; cpu_addr = 32'h8000_0456; cpu_we = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        check(io_addr == 16'h0123, "R10 addr unchanged while busy",
              {16'b0, io_addr}, 32'h0123);
        io_rdata = 32'h0000_00A5; io_rvalid = 1'b1;
        cpu_req = 1'b1;
        @(negedge clk);
        io_rvalid = 1'b0;
        check(cpu_done && cpu_rdata == 32'hA5, "R10 read completes",
              cpu_rdata, 32'hA5);
        @(negedge clk);
        cpu_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (io_wr || io_rd) extra = 1'b1;
            @(negedge clk);
        end
        check(!extra, "R10 no strobe from busy request", {31'b0, extra}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_write(32'h8000_03F8, 2'b00, 32'h0000_0041, 1'b0);
        t_write(32'h8012_3456, 2'b01, 32'hCAFE_1234, 1'b0);
        t_write(32'h807F_F01F, 2'b10, 32'h1122_3344, 1'b1);
        t_write(32'h8001_F000, 2'b10, 32'hA1B2_C3D4, 1'b1);
        t_read (32'h8000_0398, 2'b00, 32'h0000_005A, 1'b0, 1'b0);
        t_read (32'h8004_2A17, 2'b01, 32'h0000_BEEF, 1'b1, 1'b1);
        t_read (32'h8000_1FFC, 2'b10, 32'h0102_0304, 1'b0, 1'b1);
        t_not_forwarded(32'h8080_0000, 2'b00, "R1 above window ignored");
        t_not_forwarded(32'h7FFF_FFFF, 2'b10, "R1 below window ignored");
        t_not_forwarded(32'h8000_0010, 2'b11, "R5 reserved size ignored");
        t_busy_ignore();
        t_write(32'h807F_FFFF, 2'b00, 32'h0000_00FF, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule